// File: doc/BRIEF.md
# Per-Channel Tristate Strobe Generator

This block drives the active-low enable strobes for the external line drivers that sit behind the serial outputs of a time-division multiplexed switch. Only sixteen output streams have a strobe. Each strobe is a series of control timeslots, and every timeslot lasts one channel time of its own stream. The number of timeslots in a frame therefore follows the output rate programmed for that stream. A strobe goes low during a channel only if a per-channel bitmap marks that channel as carrying data. A channel marked unused keeps its strobe high.

A single frame counter runs on the 16.384 MHz master clock. A frame pulse clears it, and it also wraps by itself at the end of each frame. Every stream works out its channel index from that counter and from its own 2-bit rate code. A new rate code is taken only at a frame boundary. The bitmap is sampled only where a channel begins, so a strobe changes only on channel edges. An enable pin and an enable bit from a control register gate every strobe. When either one is low, or when reset is active, all strobes are high and a tristate flag is raised for the serial data outputs.

Top module: `tristate_strobe_gen`

## Requirements
- R1: While `rst_ni` is low, every bit of `oe_n_o` is 1 and `data_hiz_o` is 1. After reset is released the frame counter starts at 0 and every stored rate code is 00.
- R2: A strobe can be low only when both `pin_en_i` and `reg_en_i` are 1. If either one is 0, every bit of `oe_n_o` is 1 in that same cycle.
- R3: Rate code `rate_i[2s+1:2s]` sets the channel time of stream s. With the default parameters, codes 00, 01, 10 and 11 give 64, 32, 16 and 8 clock cycles per channel, that is 32, 64, 128 and 256 channels in a frame of 2048 cycles.
- R4: During channel c of stream s, `oe_n_o[s]` is low exactly when `used_i[s*FAST_CH + c]` is 1 (while enabled). Bitmap bits above the stream's channel count have no effect.
- R5: A clock edge with `fp_i` high sets the frame counter to 0, so channel 0 of every stream begins in the cycle that follows that edge.
- R6: If no frame pulse arrives, the counter wraps from the last cycle of the frame back to 0, and a new frame begins.
- R7: A change of rate code takes effect only at a frame boundary (a frame pulse or a wrap). Until then the stream keeps the old channel timing.
- R8: The bitmap is sampled only on the first cycle of a channel. A change to the bitmap in the middle of a channel leaves `oe_n_o` unchanged until the next channel boundary of that stream.
- R9: `data_hiz_o` is 0 only when `rst_ni`, `pin_en_i` and `reg_en_i` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, 16.384 MHz |
| rst_ni | input | 1 | Synchronous reset, active low |
| fp_i | input | 1 | Frame pulse; clears the frame counter |
| pin_en_i | input | 1 | Enable pin for the driver strobes |
| reg_en_i | input | 1 | Enable bit from a control register |
| rate_i | input | 2*NSTRM | 2-bit rate code per stream (00 slowest, 11 fastest) |
| used_i | input | NSTRM*FAST_CH | Channel-in-use bitmap; bit s*FAST_CH+c belongs to channel c of stream s |
| oe_n_o | output | NSTRM | Active-low driver enable strobe per stream |
| data_hiz_o | output | 1 | High when all serial data outputs must be tristated |

## Verification
The bench builds the block with FAST_CH = 16 and BIT_CYC = 1. This makes a frame 128 cycles long, and the four rates give 2, 4, 8 and 16 channels of 64, 32, 16 and 8 cycles. At that size the bench can compare every stream on every cycle of several whole frames. Those frames cover all four rates at once, frames started by a pulse and frames started by a wrap, rate codes changed in mid-frame, and bitmap changes in mid-channel. The bench also takes each enable away in the middle of a frame.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    typedef logic [1:0] rate_t;
    localparam int unsigned BITS_PER_CHAN = 8;
    localparam rate_t RATE_SLOWEST = 2'b00;
    localparam rate_t RATE_FASTEST = 2'b11;
endpackage

// File: rtl/tsc_frame_timer.sv
module tsc_frame_timer #(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fp_i,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_nxt_o,
    output logic             frame_start_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fp_i) st_d.cnt = '0;
        else      st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_q_o       = st_q.cnt;
    assign cnt_nxt_o     = st_d.cnt;
    assign frame_start_o = (st_d.cnt == '0);

    // R5: a frame pulse restarts the count
    assert_pulse_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fp_i |=> (cnt_q_o == '0));

    // R6: without a pulse the count advances by one and wraps
    assert_count_steps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fp_i && $past(rst_ni)) |=> (cnt_q_o == CNT_W'($past(cnt_q_o) + 1'b1)));
endmodule

// File: rtl/tsc_stream_slot.sv
module tsc_stream_slot
    import tsc_pkg::*;
#(
    parameter int unsigned CNT_W   = 11,
    parameter int unsigned CHI_W   = 8,
    parameter int unsigned FAST_CH = 256,
    parameter int unsigned BASE_SH = 3
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [CNT_W-1:0]   cnt_q_i,
    input  logic [CNT_W-1:0]   cnt_nxt_i,
    input  logic               frame_start_i,
    input  rate_t              rate_i,
    input  logic [FAST_CH-1:0] used_i,
    output logic               strb_n_o
);
    typedef struct packed {
        rate_t rate;
        logic  strb_n;
    } slot_t;

    slot_t st_d, st_q;

    logic [CNT_W-1:0] mask_nxt;
    logic [CHI_W-1:0] chan_nxt;
    logic             chan_edge;

    function automatic logic [CNT_W-1:0] chan_mask(input rate_t r);
        int unsigned sh;
        sh = BASE_SH + (32'd3 - 32'(r));
        return CNT_W'((32'd1 << sh) - 32'd1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (frame_start_i) st_d.rate = rate_i;
        mask_nxt  = chan_mask(st_d.rate);
        chan_edge = ((cnt_nxt_i & mask_nxt) == '0);
        chan_nxt  = CHI_W'(cnt_nxt_i >> (BASE_SH + (32'd3 - 32'(st_d.rate))));
        if (chan_edge) st_d.strb_n = ~used_i[chan_nxt];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '{rate: RATE_SLOWEST, strb_n: 1'b1};
        else         st_q <= st_d;
    end

    assign strb_n_o = st_q.strb_n;

    // R8: strobe holds for the whole channel
    assert_hold_in_chan_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cnt_q_i & chan_mask(st_q.rate)) != '0) |-> $stable(st_q.strb_n));

    // R7: rate only moves at the frame start
    assert_rate_at_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(st_q.rate) |-> (cnt_q_i == '0));
endmodule

// File: rtl/tristate_strobe_gen.sv
module tristate_strobe_gen
    import tsc_pkg::*;
#(
    parameter int unsigned NSTRM   = 16,
    parameter int unsigned FAST_CH = 256,
    parameter int unsigned BIT_CYC = 1
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       fp_i,
    input  logic                       pin_en_i,
    input  logic                       reg_en_i,
    input  logic [2*NSTRM-1:0]         rate_i,
    input  logic [NSTRM*FAST_CH-1:0]   used_i,
    output logic [NSTRM-1:0]           oe_n_o,
    output logic                       data_hiz_o
);
    localparam int unsigned CHAN_CYC = BITS_PER_CHAN * BIT_CYC;
    localparam int unsigned BASE_SH  = $clog2(CHAN_CYC);
    localparam int unsigned CHI_W    = $clog2(FAST_CH);
    localparam int unsigned CNT_W    = $clog2(FAST_CH * CHAN_CYC);

    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic             frame_start;
    logic [NSTRM-1:0] strb_n;
    logic             en_all;

    tsc_frame_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .fp_i          (fp_i),
        .cnt_q_o       (cnt_q),
        .cnt_nxt_o     (cnt_nxt),
        .frame_start_o (frame_start)
    );

    for (genvar s = 0; s < NSTRM; s++) begin : g_slot
        tsc_stream_slot #(
            .CNT_W   (CNT_W),
            .CHI_W   (CHI_W),
            .FAST_CH (FAST_CH),
            .BASE_SH (BASE_SH)
        ) u_slot (
            .clk_i         (clk_i),
            .rst_ni        (rst_ni),
            .cnt_q_i       (cnt_q),
            .cnt_nxt_i     (cnt_nxt),
            .frame_start_i (frame_start),
            .rate_i        (rate_i[2*s +: 2]),
            .used_i        (used_i[s*FAST_CH +: FAST_CH]),
            .strb_n_o      (strb_n[s])
        );
    end

    always_comb begin
        en_all     = rst_ni & pin_en_i & reg_en_i;
        data_hiz_o = ~en_all;
        oe_n_o     = strb_n | {NSTRM{~en_all}};
    end

    // R2: no strobe may be active while disabled
    always_comb begin
        if (!(pin_en_i && reg_en_i))
            assert_off_when_disabled_R2: assert (&oe_n_o);
    end

    // R9: data outputs float whenever any strobe could be forced
    assert_hiz_tracks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (oe_n_o != '1) |-> !data_hiz_o);
endmodule

// File: tb/sim_tristate_strobe_gen.sv
module sim_tristate_strobe_gen;
    localparam int NSTRM   = 16;
    localparam int FAST_CH = 16;
    localparam int FRAME   = FAST_CH * 8;

    logic clk = 0;
    logic rst_n = 0, fp = 0, pin_en = 0, reg_en = 0;
    logic [2*NSTRM-1:0]       rate = '0;
    logic [NSTRM*FAST_CH-1:0] used = '0;
    logic [NSTRM-1:0]         oe_n;
    logic                     hiz;

    int nvec = 0, nbad = 0;
    int k = 0;
    logic [1:0]       rate_m [NSTRM];
    logic [NSTRM-1:0] bit_m = '0;

    always #4 clk = ~clk;

    tristate_strobe_gen #(.NSTRM(NSTRM), .FAST_CH(FAST_CH), .BIT_CYC(1)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .fp_i(fp), .pin_en_i(pin_en),
        .reg_en_i(reg_en), .rate_i(rate), .used_i(used),
        .oe_n_o(oe_n), .data_hiz_o(hiz)
    );

    task automatic step(input string tag);
        logic [NSTRM-1:0] exp_oe;
        logic en;
        @(posedge clk);
        if (!rst_n) begin
            k = 0; bit_m = '0;
            for (int s = 0; s < NSTRM; s++) rate_m[s] = 2'b00;
        end else begin
            k = fp ? 0 : (k + 1) % FRAME;
            if (k == 0) for (int s = 0; s < NSTRM; s++) rate_m[s] = rate[2*s +: 2];
            for (int s = 0; s < NSTRM; s++) begin
                int sh;
                sh = 6 - int'(rate_m[s]);
                if ((k & ((1 << sh) - 1)) == 0) bit_m[s] = used[s*FAST_CH + (k >> sh)];
            end
        end
        @(negedge clk);
        en = rst_n & pin_en & reg_en;
        exp_oe = en ? ~bit_m : '1;
        nvec++;
        if (oe_n !== exp_oe || hiz !== !en) begin
            nbad++;
            $display("FAIL %s k=%0d oe_n=%h exp=%h hiz=%b exp=%b", tag, k, oe_n, exp_oe, hiz, !en);
        end
    endtask

    task automatic set_rates(input int off);
        for (int s = 0; s < NSTRM; s++) rate[2*s +: 2] = 2'((s + off) % 4);
    endtask

    task automatic set_map(input int seed);
        for (int i = 0; i < NSTRM*FAST_CH; i++) used[i] = (((i * seed) + (i >> 3)) % 5) < 2;
    endtask

    task automatic pulse(input string tag);
        fp = 1; step(tag); fp = 0;
    endtask

    initial begin
        #2_000_000;
        nbad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < 4; i++) step("R1");
        rst_n = 1; pin_en = 1; reg_en = 1;
        set_rates(0); set_map(7);
        step("R1");
        pulse("R5");
        for (int i = 0; i < FRAME - 1; i++) step("R3");
        for (int i = 0; i < FRAME + 5; i++) step("R6");
        set_map(3); pulse("R4");
        for (int i = 0; i < 50; i++) step("R4");
        set_rates(1);
        for (int i = 0; i < 30; i++) step("R7");
        used = ~used;
        for (int i = 0; i < 40; i++) step("R8");
        pulse("R7");
        for (int i = 0; i < 40; i++) step("R7");
        pin_en = 0;
        for (int i = 0; i < 20; i++) step("R2");
        pin_en = 1; reg_en = 0;
        for (int i = 0; i < 20; i++) step("R9");
        reg_en = 1;
        for (int i = 0; i < 60; i++) step("R2");
        for (int r = 0; r < 4; r++) begin
            for (int s = 0; s < NSTRM; s++) rate[2*s +: 2] = 2'(r);
            used = (r % 2 == 0) ? '1 : '0;
            if (r == 3) used = {NSTRM{16'h00A5}};
            pulse("R3");
            for (int i = 0; i < FRAME; i++) step("R4");
        end
        rst_n = 0;
        for (int i = 0; i < 3; i++) step("R1");
        rst_n = 1;
        for (int i = 0; i < 20; i++) step("R1");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule